// File: doc/BRIEF.md
# Floppy Controller Host Command Interface

This block presents the host side of a floppy disk controller as eight byte-wide registers. The host loads a command one byte at a time through a data port. Before each byte it polls a main status byte, which says when the port is ready and in which direction the next byte moves. The block decodes the command and carries it out against a model of head position for each of four drives. It then either returns to idle or offers a short sequence of result bytes.

Seek and recalibrate move the modelled head one cylinder per step period. The step period is set by the specify command. When the move ends, the block raises an interrupt, and a later sense-interrupt command reports which drive finished. Read and write commands do not touch any media. They exchange a fixed number of bytes over a request/acknowledge pair and then report normal completion.

Releasing the controller from its held-reset state raises an interrupt. The host must then collect four polling reports, one for each drive.

Top module: `fdc_host_if`

## Requirements
- R1: After `rst_n` is released, the output control byte (offset 2) reads 0x00, the controller is held in reset, the main status byte (offset 4) reads 0x00, and `irq` and `dma_req` are low.
- R2: While bit 2 of the output control byte is 0, all of the following hold. Writes to the data port (offset 5) are ignored. The pending interrupt is cleared. Every drive's present cylinder and seek-complete flag are cleared. The main status byte reads 0x00.
- R3: A write that changes bit 2 of the output control byte from 0 to 1 sets the pending interrupt. The next four sense-interrupt commands (opcode 0x08) then return ST0 = 0xC0 | d and cylinder 0, for d = 0, 1, 2, 3 in that order. `irq` equals the pending interrupt ANDed with bit 3 of the output control byte.
- R4: The main status byte is laid out as follows: bit 7 is ready, bit 6 is direction (1 means a result byte is waiting), bit 5 is always 0, bit 4 is command busy, and bits 3:0 are per-drive seek busy.
- R5: The ready bit reads 0 in the clock after any data-port access and for as long as a command executes. A data-port write made while ready is 0 or direction is 1 is ignored.
- R6: Result bytes are read from the data port while direction is 1, in order. The first result read clears the pending interrupt. After the last result byte, the main status byte returns to 0x80.
- R7: The version command (0x10) returns the single byte 0x90.
- R8: A seek is three bytes: 0x0F, then (head<<2)|drive, then the target cylinder. While the head moves, bit `drive` of the main status byte is set. Each cylinder step takes (16 - SRT) * STEP_UNIT clocks, so a move of n cylinders completes n*(16-SRT)*STEP_UNIT + 1 clocks after the last command byte. Completion sets the pending interrupt. The following sense interrupt returns ST0 = 0x20 | (head<<2) | drive, then the cylinder.
- R9: A recalibrate is two bytes: 0x07, then the drive. It moves that drive to cylinder 0. The following sense interrupt returns 0x20 | drive, then 0.
- R10: A specify is three bytes: 0x03, then SRT<<4 | unload time, then a third byte that is ignored. SRT sets the step period, it is 0 after reset, and the command has no result phase.
- R11: Read and write commands are selected by opcode bits 4:0 equal to 0x06 or 0x05; bits 7:5 are ignored. Each is nine bytes. After the last byte, `dma_req` stays high until XFER_BYTES clocks with `dma_ack` high have been counted. The command then sets the pending interrupt and returns seven bytes: (head<<2)|drive, 0, 0, and command bytes 2, 3, 4 and 5 (cylinder, head, sector, size).
- R12: An unknown opcode is taken as a one-byte command and returns the single byte 0x80. A sense interrupt with nothing to report also returns 0x80.
- R13: Offset 2 reads back the byte last written to it. Offset 3 reads back bits 1:0 of the byte last written to it. A write to offset 4 or 7 sets a 2-bit rate, which offset 7 returns in bits 2:1. Offset 0 returns the pending interrupt in bit 7. Offset 1 returns the drive-select bits 1:0 of the output control byte.
- R14: When several drives have finished seeking, successive sense interrupts report them lowest drive number first, and each drive is reported once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read; side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Transfer request during the data phase |
| dma_ack | input | 1 | Transfer acknowledge, one byte per clock while high |

## Verification
The bench builds the block with STEP_UNIT = 2 and XFER_BYTES = 16. At these values a multi-cylinder seek lasts a few dozen clocks, so its length can be counted exactly against the step-rate formula for two different specify settings. The shortened transfer lets the bench count every acknowledge of a full read and a full write. It can then follow each with the seven-byte result read-out, the interrupt clear, and the polling sequence after a second controller reset.

// File: rtl/fdc_host_if.sv
module fdc_host_if #(
  parameter int STEP_UNIT = 8,
  parameter int XFER_BYTES = 512,
  parameter logic [7:0] VERSION_ID = 8'h90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       dma_req,
  input  logic       dma_ack
);
  localparam int STW = $clog2(16 * STEP_UNIT + 1);
  localparam int XW  = $clog2(XFER_BYTES + 1);
  localparam logic [4:0] OP_SPEC = 5'h03, OP_WR = 5'h05, OP_RD = 5'h06, OP_RECAL = 5'h07,
                         OP_SENSE = 5'h08, OP_SEEK = 5'h0F, OP_VER = 5'h10;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_t;

  phase_t          phase;
  logic [7:0]      dor;
  logic [1:0]      tape, rate;
  logic [7:0]      cmdb [6];
  logic [3:0]      cmd_cnt;
  logic [7:0]      res [7];
  logic [2:0]      res_len, res_idx;
  logic            gap, int_q;
  logic [2:0]      poll_cnt;
  logic [3:0]      srt;
  logic [7:0]      pcn [4];
  logic [3:0]      sk_done, sk_head;
  logic [STW-1:0]  step_cnt, per;
  logic [XW-1:0]   xfer_cnt;
  logic [7:0]      msr, tgt;
  logic [4:0]      op;
  logic [1:0]      drv, sel_d, pdrv;
  logic            ctrl_on, rqm, dio, busy, seek_op, rw_op, fifo_wr, fifo_rd, fifo_acc;
  logic [3:0]      drv_busy;

  function automatic logic [3:0] cmd_len(input logic [4:0] o);
    case (o)
      OP_RD, OP_WR:     return 4'd9;
      OP_SPEC, OP_SEEK: return 4'd3;
      OP_RECAL:         return 4'd2;
      default:          return 4'd1;
    endcase
  endfunction

  assign ctrl_on  = dor[2];
  assign op       = cmdb[0][4:0];
  assign drv      = cmdb[1][1:0];
  assign seek_op  = (op == OP_SEEK) || (op == OP_RECAL);
  assign rw_op    = (op == OP_RD) || (op == OP_WR);
  assign tgt      = (op == OP_RECAL) ? 8'd0 : cmdb[2];
  assign per      = STW'((16 - int'(srt)) * STEP_UNIT);
  assign pdrv     = ~poll_cnt[1:0] + 2'd1;

  assign rqm      = ctrl_on && !gap && (phase == PH_CMD || phase == PH_RES);
  assign dio      = ctrl_on && (phase == PH_RES);
  assign busy     = ctrl_on && (phase != PH_CMD || cmd_cnt != 4'd0);
  assign drv_busy = (ctrl_on && phase == PH_EXEC && seek_op) ? (4'b0001 << drv) : 4'b0000;
  assign msr      = {rqm, dio, 1'b0, busy, drv_busy};

  assign fifo_acc = (bus_wr || bus_rd) && bus_addr == 3'd5;
  assign fifo_wr  = bus_wr && bus_addr == 3'd5 && rqm && !dio;
  assign fifo_rd  = bus_rd && bus_addr == 3'd5 && rqm && dio;

  assign irq      = int_q & dor[3];
  assign dma_req  = ctrl_on && phase == PH_EXEC && rw_op;

  always_comb begin
    sel_d = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (sk_done[i]) sel_d = 2'(i);
  end

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = {int_q, 7'd0};
      3'd1: bus_rdata = {6'd0, dor[1:0]};
      3'd2: bus_rdata = dor;
      3'd3: bus_rdata = {6'd0, tape};
      3'd4: bus_rdata = msr;
      3'd5: bus_rdata = dio ? res[res_idx] : 8'h00;
      3'd7: bus_rdata = {5'd0, rate, 1'b0};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      dor      <= 8'h00;
      tape     <= 2'd0;
      rate     <= 2'd0;
      cmd_cnt  <= 4'd0;
      res_len  <= 3'd1;
      res_idx  <= 3'd0;
      gap      <= 1'b0;
      int_q    <= 1'b0;
      poll_cnt <= 3'd0;
      srt      <= 4'd0;
      sk_done  <= 4'd0;
      sk_head  <= 4'd0;
      step_cnt <= '0;
      xfer_cnt <= '0;
      for (int i = 0; i < 6; i++) cmdb[i] <= 8'h00;
      for (int i = 0; i < 7; i++) res[i] <= 8'h00;
      for (int i = 0; i < 4; i++) pcn[i] <= 8'h00;
    end else begin
      gap <= fifo_acc;
      if (bus_wr) begin
        case (bus_addr)
          3'd2: dor <= bus_wdata;
          3'd3: tape <= bus_wdata[1:0];
          3'd4, 3'd7: rate <= bus_wdata[1:0];
          default: ;
        endcase
      end
      if (!ctrl_on) begin
        phase    <= PH_CMD;
        cmd_cnt  <= 4'd0;
        res_idx  <= 3'd0;
        int_q    <= 1'b0;
        poll_cnt <= 3'd0;
        sk_done  <= 4'd0;
        for (int i = 0; i < 4; i++) pcn[i] <= 8'h00;
        if (bus_wr && bus_addr == 3'd2 && bus_wdata[2]) begin
          int_q    <= 1'b1;
          poll_cnt <= 3'd4;
        end
      end else begin
        case (phase)
          PH_CMD: if (fifo_wr) begin
            if (cmd_cnt < 4'd6) cmdb[cmd_cnt[2:0]] <= bus_wdata;
            if (cmd_len(cmd_cnt == 4'd0 ? bus_wdata[4:0] : op) == cmd_cnt + 4'd1) begin
              phase    <= PH_EXEC;
              cmd_cnt  <= 4'd0;
              step_cnt <= '0;
              xfer_cnt <= '0;
            end else begin
              cmd_cnt <= cmd_cnt + 4'd1;
            end
          end
          PH_EXEC: begin
            case (op)
              OP_VER: begin
                res[0]  <= VERSION_ID;
                res_len <= 3'd1;
                phase   <= PH_RES;
              end
              OP_SPEC: begin
                srt   <= cmdb[1][7:4];
                phase <= PH_CMD;
              end
              OP_SENSE: begin
                if (poll_cnt != 3'd0) begin
                  res[0]   <= {6'b110000, pdrv};
                  res[1]   <= pcn[pdrv];
                  res_len  <= 3'd2;
                  poll_cnt <= poll_cnt - 3'd1;
                end else if (|sk_done) begin
                  res[0]         <= {5'b00100, sk_head[sel_d], sel_d};
                  res[1]         <= pcn[sel_d];
                  res_len        <= 3'd2;
                  sk_done[sel_d] <= 1'b0;
                end else begin
                  res[0]  <= 8'h80;
                  res_len <= 3'd1;
                end
                phase <= PH_RES;
              end
              OP_SEEK, OP_RECAL: begin
                if (step_cnt != '0) begin
                  step_cnt <= step_cnt - 1'b1;
                end else if (pcn[drv] == tgt) begin
                  sk_done[drv] <= 1'b1;
                  sk_head[drv] <= (op == OP_SEEK) ? cmdb[1][2] : 1'b0;
                  int_q        <= 1'b1;
                  phase        <= PH_CMD;
                end else begin
                  pcn[drv] <= (pcn[drv] < tgt) ? pcn[drv] + 8'd1 : pcn[drv] - 8'd1;
                  step_cnt <= per - 1'b1;
                end
              end
              OP_RD, OP_WR: if (dma_ack) begin
                if (xfer_cnt == XW'(XFER_BYTES - 1)) begin
                  res[0]  <= {5'd0, cmdb[1][2:0]};
                  res[1]  <= 8'h00;
                  res[2]  <= 8'h00;
                  res[3]  <= cmdb[2];
                  res[4]  <= cmdb[3];
                  res[5]  <= cmdb[4];
                  res[6]  <= cmdb[5];
                  res_len <= 3'd7;
                  int_q   <= 1'b1;
                  phase   <= PH_RES;
                end else begin
                  xfer_cnt <= xfer_cnt + 1'b1;
                end
              end
              default: begin
                res[0]  <= 8'h80;
                res_len <= 3'd1;
                phase   <= PH_RES;
              end
            endcase
          end
          PH_RES: if (fifo_rd) begin
            int_q <= 1'b0;
            if (res_idx == res_len - 3'd1) begin
              res_idx <= 3'd0;
              phase   <= PH_CMD;
            end else begin
              res_idx <= res_idx + 3'd1;
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/fdc_host_if_chk.sv
module fdc_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] dor,
  input logic       int_q,
  input logic [2:0] poll_cnt,
  input logic [7:0] msr,
  input logic       dma_req
);
  AST_RQM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr == 3'd5) |=> !msr[7]); // R5

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!dor[2] && $past(!dor[2])) |-> (!int_q && msr == 8'h00)); // R2

  AST_RELEASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dor[2]) |-> (int_q && poll_cnt == 3'd4)); // R3

  AST_ONE_DRIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(msr[3:0])); // R8

  AST_DMA_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (msr[4] && !msr[7])); // R11

  AST_RESULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5 && msr[7] && msr[6]) |=> !int_q); // R6
endmodule

bind fdc_host_if fdc_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .dor(dor), .int_q(int_q), .poll_cnt(poll_cnt), .msr(msr), .dma_req(dma_req)
);

// File: tb/fdc_host_if_test.sv
module fdc_host_if_test;
  localparam int SU = 2;
  localparam int XB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, dma_ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq, dma_req;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  fdc_host_if #(.STEP_UNIT(SU), .XFER_BYTES(XB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [7:0] m;
    for (int i = 0; i < 500; i++) begin
      peek(3'd4, m);
      if (m[7] && !m[6]) begin
        wr_reg(3'd5, b);
        return;
      end
    end
    check("R5 ready for command byte", 0, 1);
  endtask

  task automatic get_byte(output logic [7:0] b);
    logic [7:0] m;
    b = 8'hEE;
    for (int i = 0; i < 500; i++) begin
      peek(3'd4, m);
      if (m[7] && m[6]) begin
        rd_reg(3'd5, b);
        return;
      end
    end
    check("R6 result byte offered", 0, 1);
  endtask

  task automatic wait_idle();
    logic [7:0] m;
    for (int i = 0; i < 2000; i++) begin
      peek(3'd4, m);
      if (!m[4]) return;
    end
    check("R4 command finishes", 0, 1);
  endtask

  task automatic sense(input int st0, input int cyl, input string req);
    logic [7:0] b;
    send_byte(8'h08);
    get_byte(b); check({req, " sense ST0"}, b, st0);
    if (st0 != 8'h80) begin
      get_byte(b); check({req, " sense cylinder"}, b, cyl);
    end
  endtask

  task automatic seek(input logic [7:0] dh, input logic [7:0] cyl);
    send_byte(8'h0F); send_byte(dh); send_byte(cyl);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(3'd2, d); check("R1 output control byte", d, 8'h00);
    rd_reg(3'd4, d); check("R1 main status", d, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 dma_req", dma_req, 0);
  endtask

  task automatic t_release();
    logic [7:0] d;
    wr_reg(3'd2, 8'h04);
    check("R3 irq gated by bit 3", irq, 0);
    rd_reg(3'd0, d); check("R13 pending bit at offset 0", d, 8'h80);
    wr_reg(3'd2, 8'h0C);
    check("R3 irq after release", irq, 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h08);
      get_byte(d); check("R3 polling ST0", d, 8'hC0 | i);
      if (i == 0) check("R6 irq cleared by first result read", irq, 0);
      get_byte(d); check("R3 polling cylinder", d, 0);
    end
    sense(8'h80, 0, "R12 nothing pending");
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr_reg(3'd3, 8'hFF); rd_reg(3'd3, d); check("R13 tape register", d, 8'h03);
    wr_reg(3'd4, 8'h02); rd_reg(3'd7, d); check("R13 rate via offset 4", d, 8'h04);
    wr_reg(3'd7, 8'h01); rd_reg(3'd7, d); check("R13 rate via offset 7", d, 8'h02);
    wr_reg(3'd2, 8'h2D); rd_reg(3'd1, d); check("R13 drive select at offset 1", d, 8'h01);
    rd_reg(3'd2, d); check("R13 output control readback", d, 8'h2D);
    wr_reg(3'd2, 8'h0C);
  endtask

  task automatic t_version();
    logic [7:0] d;
    send_byte(8'h10);
    rd_reg(3'd4, d); check("R5 ready low after data-port write", d[7], 0);
    get_byte(d); check("R7 version byte", d, 8'h90);
    rd_reg(3'd4, d);
    rd_reg(3'd4, d); check("R6 status idle after result", d, 8'h80);
  endtask

  task automatic t_invalid();
    logic [7:0] d;
    send_byte(8'h1F);
    get_byte(d); check("R12 invalid opcode result", d, 8'h80);
    rd_reg(3'd4, d);
    rd_reg(3'd4, d); check("R12 single result byte", d, 8'h80);
  endtask

  task automatic t_seek_timing();
    logic [7:0] d;
    int cnt;
    send_byte(8'h03); send_byte(8'hC0); send_byte(8'h00);
    wait_idle();
    rd_reg(3'd4, d); check("R10 specify has no result", d, 8'h80);
    seek(8'h00, 8'd5);
    peek(3'd4, d); check("R8 R4 drive 0 busy status", d, 8'h11);
    cnt = 1;
    for (int i = 0; i < 1000 && d[0]; i++) begin
      peek(3'd4, d);
      if (d[0]) cnt++;
    end
    check("R8 R10 seek length srt 12", (cnt >= 5*4*SU && cnt <= 5*4*SU+2) ? 1 : 0, 1);
    check("R8 seek-end irq", irq, 1);
    send_byte(8'h03); send_byte(8'h80); send_byte(8'h00);
    seek(8'h00, 8'd3);
    peek(3'd4, d);
    cnt = 1;
    for (int i = 0; i < 1000 && d[0]; i++) begin
      peek(3'd4, d);
      if (d[0]) cnt++;
    end
    check("R10 seek length srt 8", (cnt >= 2*8*SU && cnt <= 2*8*SU+2) ? 1 : 0, 1);
    sense(8'h20, 3, "R8");
  endtask

  task automatic t_gap();
    logic [7:0] d;
    for (int i = 0; i < 50; i++) begin
      peek(3'd4, d);
      if (d[7]) break;
    end
    wr_reg(3'd5, 8'h0F);
    wr_reg(3'd5, 8'h05);
    send_byte(8'h01); send_byte(8'd3);
    wait_idle();
    sense(8'h21, 3, "R5 write during gap ignored");
  endtask

  task automatic t_order();
    seek(8'h06, 8'd4); wait_idle();
    seek(8'h01, 8'd2); wait_idle();
    sense(8'h21, 2, "R14 lowest drive first");
    sense(8'h26, 4, "R14 next drive with head");
    sense(8'h80, 0, "R14 each drive reported once");
  endtask

  task automatic t_recal();
    send_byte(8'h07); send_byte(8'h02); wait_idle();
    sense(8'h22, 0, "R9 recalibrate");
  endtask

  task automatic t_xfer(input logic [7:0] opc, input logic [7:0] dh, input logic [7:0] c,
                        input logic [7:0] h, input logic [7:0] s);
    logic [7:0] d;
    logic [7:0] exp [7];
    int acks = 0;
    bit seen = 0;
    send_byte(opc); send_byte(dh); send_byte(c); send_byte(h);
    send_byte(s); send_byte(8'h02); send_byte(8'd18); send_byte(8'h1B); send_byte(8'hFF);
    for (int i = 0; i < 200; i++) begin
      if (dma_req) begin
        if (!seen) begin
          peek(3'd4, d); check("R11 status during transfer", d, 8'h10);
        end
        seen = 1; acks++; dma_ack = 1'b1;
      end else begin
        dma_ack = 1'b0;
        if (seen) break;
      end
      @(negedge clk);
    end
    dma_ack = 1'b0;
    check("R11 acknowledge count", acks, XB);
    check("R11 completion irq", irq, 1);
    exp = '{dh & 8'h07, 8'h00, 8'h00, c, h, s, 8'h02};
    for (int i = 0; i < 7; i++) begin
      get_byte(d); check("R11 result byte", d, exp[i]);
    end
  endtask

  task automatic t_hold();
    logic [7:0] d;
    seek(8'h03, 8'd1); wait_idle();
    check("R8 irq before hold", irq, 1);
    wr_reg(3'd2, 8'h08);
    wr_reg(3'd5, 8'h10);
    check("R2 irq cleared in hold", irq, 0);
    rd_reg(3'd4, d); check("R2 status in hold", d, 8'h00);
    wr_reg(3'd2, 8'h0C);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h08);
      get_byte(d); check("R2 R3 polling after hold", d, 8'hC0 | i);
      get_byte(d); check("R2 cylinder cleared", d, 0);
    end
    sense(8'h80, 0, "R2 seek flags cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_release();
    t_regs();
    t_version();
    t_invalid();
    t_seek_timing();
    t_gap();
    t_order();
    t_recal();
    t_xfer(8'hE6, 8'h01, 8'd7, 8'd0, 8'd3);
    t_xfer(8'h45, 8'h04, 8'd2, 8'd1, 8'd9);
    t_hold();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule